// File: doc/BRIEF.md
# Two-Step Armed Watchdog Timer

This block guards a processor against a stalled program. An 8-bit down counter advances only on single-cycle enable pulses coming from an external prescaler. Software starts and refreshes it through one 8-bit control register. A refresh takes two separate writes. The first raises the arm bit. A later write then raises the load bit. A load bit edge that was not preceded by an arm edge does nothing.

A refresh loads the 4-bit preset into the upper nibble of the counter and sets the lower nibble to all ones. After reset the counter stands still and counts no prescaler ticks. The first valid refresh starts it, and from then on software can refresh it but cannot stop it.

When the count is about to run out, the block first raises a sticky early-warning interrupt. One tick later it fires a single-cycle processor reset pulse and returns to the stopped state.

Top module: `armedWatchdog`

## Requirements
- R1: After reset, rdData reads 0x00 and irq and wdReset are low. The counter does not run, so prescaler ticks raise neither irq nor wdReset until a valid load occurs.
- R2: The control register layout is: bit 7 arm, bits 6..3 preset (bit 6 most significant), bit 2 a stored polarity control, bit 1 reserved, bit 0 load. rdData returns the last written value with bit 1 always reading 0.
- R3: While running, the counter decreases by one on each cycle with tick high. It does not change on cycles without a tick.
- R4: A valid load happens when a write raises bit 0 from 0 to 1 after an earlier, separate write raised bit 7 from 0 to 1. It sets the counter to {preset, 4'b1111} and starts it.
- R5: A load edge with no prior arm edge is ignored. This includes a write that raises bit 7 and bit 0 together, which arms but does not load.
- R6: A valid load consumes the armed state, so the next load needs a fresh arm edge.
- R7: After a valid load with preset P, irq rises after tick number 16*P+14 and wdReset pulses high for exactly one cycle after tick number 16*P+15. With P=15 these are ticks 254 and 255.
- R8: After the reset pulse the counter is stopped, and further ticks produce no more reset pulses until the next valid load.
- R9: irq stays high until irqClr is asserted or a valid load occurs. A tick that raises irq wins over a simultaneous irqClr.
- R10: Writes that clear the arm or load bits do not stop a running counter. A valid load before expiry restarts the full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write value |
| rdData | output | 8 | Control register readback |
| tick | input | 1 | Prescaler enable pulse, one per count |
| irqClr | input | 1 | Clears the early-warning interrupt |
| irq | output | 1 | Sticky early-warning interrupt |
| wdReset | output | 1 | One-cycle processor reset pulse |

## Verification
Every result here is one register stage after its cause. A write changes rdData and the counter at the clock edge that accepts it. The tick that brings the count to 1 sets irq at the same edge, and the tick from 1 to 0 drives wdReset high for that following cycle only. The bench drives writes and ticks on falling edges and samples one falling edge later. It counts ticks one by one, so irq and wdReset are checked on the exact tick where they are due and on the tick before it.

// File: rtl/wdPkg.sv
package wdPkg;
  localparam int REG_W   = 8;
  localparam int PRE_W   = 4;
  localparam int ARM_BIT = 7;
  localparam int PRE_HI  = 6;
  localparam int PRE_LO  = 3;
  localparam int POL_BIT = 2;
  localparam int RSV_BIT = 1;
  localparam int LD_BIT  = 0;

  typedef struct packed {
    logic             doLoad;
    logic [PRE_W-1:0] preset;
    logic             clrIrq;
  } wdStrobe_t;
endpackage

// File: rtl/wdCtrl.sv
module wdCtrl
  import wdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             irqClr,
  output logic [REG_W-1:0] rdData,
  output wdStrobe_t        strobe
);
  localparam logic [REG_W-1:0] RSV_MASK = REG_W'(1) << RSV_BIT;

  logic [REG_W-1:0] ctlReg;
  logic             armed;
  logic             armRise;
  logic             ldRise;
  logic             validLoad;

  // edges: compare the new value with the stored value of the same bit
  assign armRise   = wrEn & wrData[ARM_BIT] & ~ctlReg[ARM_BIT];
  assign ldRise    = wrEn & wrData[LD_BIT] & ~ctlReg[LD_BIT];
  // arming must come from an earlier write: use the state before this one
  assign validLoad = ldRise & armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
      armed  <= 1'b0;
    end else begin
      if (wrEn) ctlReg <= wrData & ~RSV_MASK;
      if (validLoad)    armed <= 1'b0;
      else if (armRise) armed <= 1'b1;
    end
  end

  always_comb begin
    strobe.doLoad = validLoad;
    strobe.preset = wrData[PRE_HI:PRE_LO];
    strobe.clrIrq = irqClr;
  end

  assign rdData = ctlReg;
endmodule

// File: rtl/wdDatapath.sv
module wdDatapath
  import wdPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             irq,
  output logic             wdReset
);
  localparam int LOW_W = CNT_W - PRE_W;

  logic tickHit;
  logic nearEnd;
  logic atEnd;

  assign tickHit = running & tick & ~strobe.doLoad;
  assign nearEnd = (cnt == CNT_W'(2));
  assign atEnd   = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
      irq     <= 1'b0;
      wdReset <= 1'b0;
    end else begin
      wdReset <= tickHit & atEnd;
      if (strobe.doLoad) begin
        cnt     <= {strobe.preset, {LOW_W{1'b1}}};
        running <= 1'b1;
      end else if (tickHit) begin
        if (atEnd) begin
          cnt     <= '0;
          running <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
      // set wins over any clear in the same cycle
      if (tickHit & nearEnd)                  irq <= 1'b1;
      else if (strobe.doLoad | strobe.clrIrq) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/armedWatchdog.sv
module armedWatchdog
  import wdPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             tick,
  input  logic             irqClr,
  output logic             irq,
  output logic             wdReset
);
  wdStrobe_t        strobe;
  logic [CNT_W-1:0] cnt;
  logic             running;

  wdCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .irqClr (irqClr),
    .rdData (rdData),
    .strobe (strobe)
  );

  wdDatapath #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .strobe  (strobe),
    .cnt     (cnt),
    .running (running),
    .irq     (irq),
    .wdReset (wdReset)
  );
endmodule

// File: rtl/wdChecker.sv
module wdChecker #(
  parameter int CNT_W = 8,
  parameter int LOW_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             doLoad,
  input logic [7:0]       rdData,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             wdReset
);
  p_rsvd_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1] == 1'b0);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !doLoad) |=> !running);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick && !doLoad) |=> ($stable(cnt) && running));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && !doLoad && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_load_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    doLoad |=> (running && (&cnt[LOW_W-1:0])));

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> (!running && cnt == '0));
endmodule

bind armedWatchdog wdChecker #(.CNT_W(CNT_W), .LOW_W(CNT_W - wdPkg::PRE_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .doLoad  (strobe.doLoad),
  .rdData  (rdData),
  .cnt     (cnt),
  .running (running),
  .wdReset (wdReset)
);

// File: tb/sim_armedWatchdog.sv
module sim_armedWatchdog;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tick = 1'b0;
  logic       irqClr = 1'b0;
  logic       irq;
  logic       wdReset;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  armedWatchdog u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .tick(tick), .irqClr(irqClr), .irq(irq), .wdReset(wdReset)
  );

  always @(posedge clk) if (rstN && wdReset) pulses++;

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clearIrq();
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic loadPreset(input logic [3:0] p);
    wr(8'h00);
    wr(8'h80);
    wr({1'b1, p, 3'b001});
  endtask

  task automatic testReset();
    checkEq("R1 rdData", rdData, 0);
    checkEq("R1 irq", irq, 0);
    checkEq("R1 wdReset", wdReset, 0);
    ticks(300);
    checkEq("R1 idle irq", irq, 0);
    checkEq("R1 idle pulses", pulses, 0);
  endtask

  task automatic testUnarmed();
    wr(8'h00);
    wr(8'h01);
    ticks(20);
    checkEq("R5 unarmed irq", irq, 0);
    checkEq("R5 unarmed pulses", pulses, 0);
    wr(8'h00);
    wr(8'h81);
    ticks(20);
    checkEq("R5 same-write irq", irq, 0);
    checkEq("R5 same-write pulses", pulses, 0);
  endtask

  task automatic testReadback();
    wr(8'hAE);
    checkEq("R2 readback", rdData, 8'hAC);
    ticks(20);
    checkEq("R2 no load", irq, 0);
  endtask

  task automatic testExpire();
    int base;
    loadPreset(4'h0);
    base = pulses;
    ticks(13);
    checkEq("R7 irq early", irq, 0);
    repeat (50) @(negedge clk);
    checkEq("R3 no tick no count", irq, 0);
    ticks(1);
    checkEq("R7 irq at 14", irq, 1);
    checkEq("R7 no pulse at 14", pulses, base);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    checkEq("R7 pulse high", wdReset, 1);
    @(negedge clk);
    checkEq("R7 pulse one cycle", wdReset, 0);
    ticks(40);
    checkEq("R8 stopped", pulses, base + 1);
    checkEq("R9 irq sticky", irq, 1);
    clearIrq();
    checkEq("R9 irqClr", irq, 0);
  endtask

  task automatic testMax();
    int base;
    loadPreset(4'hF);
    base = pulses;
    ticks(253);
    checkEq("R7 max irq early", irq, 0);
    ticks(1);
    checkEq("R7 max irq 254", irq, 1);
    checkEq("R7 max no pulse", pulses, base);
    ticks(1);
    checkEq("R7 max pulse 255", pulses, base + 1);
    clearIrq();
  endtask

  task automatic testConsume();
    int base;
    loadPreset(4'h0);
    base = pulses;
    ticks(8);
    wr(8'h80);
    wr(8'h81);
    ticks(5);
    checkEq("R6 irq early", irq, 0);
    ticks(1);
    checkEq("R6 reload ignored", irq, 1);
    ticks(1);
    checkEq("R6 pulse", pulses, base + 1);
    clearIrq();
  endtask

  task automatic testReload();
    int base;
    loadPreset(4'h1);
    base = pulses;
    ticks(20);
    wr(8'h00);
    ticks(2);
    loadPreset(4'h1);
    ticks(29);
    checkEq("R10 restart irq early", irq, 0);
    checkEq("R10 not stopped pulses", pulses, base);
    ticks(1);
    checkEq("R10 restart irq", irq, 1);
    loadPreset(4'h1);
    checkEq("R9 load clears irq", irq, 0);
    ticks(29);
    tick = 1'b1; irqClr = 1'b1;
    @(negedge clk);
    tick = 1'b0; irqClr = 1'b0;
    @(negedge clk);
    checkEq("R9 set wins", irq, 1);
    ticks(1);
    checkEq("R10 final pulse", pulses, base + 1);
    clearIrq();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnarmed();
    testReadback();
    testExpire();
    testMax();
    testConsume();
    testReload();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule